// File: doc/BRIEF.md
# Per-Processor Interrupt Acceptor

This block sits beside one processor and takes interrupt vectors handed to it by a distribution fabric. Each delivered vector sets one bit in a 256-entry pending set. The acceptor raises a request line toward the processor whenever the highest pending vector outranks everything the processor is already servicing. Rank is read from the vector number itself: a bigger number wins, and the top four bits form a priority class.

When the processor acknowledges, the winning vector moves from the pending set to an in-service set and is returned one cycle later. If nothing can be presented at that moment, the acceptor returns a software-programmed spurious vector and leaves both sets alone. Software writes an end-of-interrupt strobe when a handler finishes. That strobe retires the highest in-service vector and sends a one-cycle pulse carrying that vector back to the fabric, so the fabric can re-arm a level-sensitive source.

A delivered vector can never be taken back. Disabling the acceptor only holds the request line low. Delivered vectors wait in the pending set until they are acknowledged.

Top module: `irq_acceptor`

## Requirements
- R1: When several vectors are pending and presentable, an acknowledge takes the numerically largest one, whatever order they arrived in.
- R2: A pending bit is cleared only by an acknowledge that takes that vector. Disabling, spurious acknowledges and end-of-interrupt writes leave it set, so it is returned by a later acknowledge.
- R3: An acknowledge in a cycle when nothing is presentable gives, on the next cycle, `ack_valid`=1, `ack_spurious`=1 and `ack_vec` equal to the last value written through `cfg_spurious`.
- R4: A spurious acknowledge changes no in-service bit. The next end-of-interrupt still retires the vector that was in service before it.
- R5: Each end-of-interrupt with at least one in-service bit set clears exactly the highest one. On the next cycle it gives a single `eoi_pulse` with `eoi_vec` equal to that vector. An end-of-interrupt with nothing in service gives no pulse and changes nothing.
- R6: `irq` is high exactly when the acceptor is enabled, a vector is pending, and either nothing is in service or bits [7:4] of the top pending vector are strictly greater than bits [7:4] of the top in-service vector.
- R7: An acknowledge while `irq` is high moves the top pending vector into service. It returns that vector on `ack_vec` with `ack_valid`=1 and `ack_spurious`=0 on the next cycle.
- R8: While the enable bit (written through `cfg_enable` with `cfg_we`) is 0, `irq` stays low and any acknowledge is spurious.
- R9: After reset the pending and in-service sets are empty, the enable bit is 0, the spurious vector is 8'hFF, and `irq`, `ack_valid` and `eoi_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | A vector is being delivered this cycle |
| dlv_vector | input | 8 | Delivered vector number |
| cfg_we | input | 1 | Write enable and spurious vector |
| cfg_enable | input | 1 | New value of the enable bit |
| cfg_spurious | input | 8 | New spurious vector |
| ack | input | 1 | Processor acknowledge, one cycle |
| eoi | input | 1 | End-of-interrupt write, one cycle |
| irq | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge response is valid |
| ack_spurious | output | 1 | Response is the spurious vector |
| ack_vec | output | 8 | Vector returned for the acknowledge |
| eoi_pulse | output | 1 | One in-service entry was retired |
| eoi_vec | output | 8 | Vector retired by the end-of-interrupt |

## Verification
The properties assume the acceptor is held in reset for at least one clock edge before use. They also assume that every input is a plain synchronous strobe or value, sampled once per edge, and that a response is only read in the cycle after the request that caused it. The stimulus raises and lowers every input two nanoseconds after a rising edge and keeps strobes high for exactly one cycle. It also drives acknowledge and end-of-interrupt at arbitrary times, including when nothing is presentable or in service, because the block has to treat those cases as legal.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
    localparam int VEC_W   = 8;
    localparam int CLASS_W = 4;
    localparam int NVEC    = 1 << VEC_W;
    localparam logic [VEC_W-1:0] SPUR_RESET = '1;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        logic spurious;
        vec_t vec;
    } ack_resp_t;

    typedef struct packed {
        logic pulse;
        vec_t vec;
    } eoi_resp_t;

    function automatic logic [CLASS_W-1:0] class_of(input vec_t v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic [N-1:0] bits,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_set.sv
module irq_vec_set #(
    parameter int N = 256,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [W-1:0] set_idx,
    input  logic         clr_en,
    input  logic [W-1:0] clr_idx,
    output logic [N-1:0] bits_q
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] set_mask, clr_mask;

    assign set_mask = set_en ? (ONE << set_idx) : '0;
    assign clr_mask = clr_en ? (ONE << clr_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= (bits_q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/irq_acceptor.sv
module irq_acceptor
    import irq_acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dlv_valid,
    input  logic [7:0] dlv_vector,
    input  logic       cfg_we,
    input  logic       cfg_enable,
    input  logic [7:0] cfg_spurious,
    input  logic       ack,
    input  logic       eoi,
    output logic       irq,
    output logic       ack_valid,
    output logic       ack_spurious,
    output logic [7:0] ack_vec,
    output logic       eoi_pulse,
    output logic [7:0] eoi_vec
);
    logic [NVEC-1:0] pend_q, isr_q;
    logic            p_found, s_found;
    vec_t            p_idx, s_idx;
    logic            enable_q;
    vec_t            spur_q;
    logic            presentable, take, retire;
    ack_resp_t       ack_q;
    eoi_resp_t       eoi_q;

    irq_vec_set #(.N(NVEC), .W(VEC_W)) u_pend (
        .clk(clk), .rst(rst),
        .set_en(dlv_valid), .set_idx(dlv_vector),
        .clr_en(take), .clr_idx(p_idx),
        .bits_q(pend_q)
    );

    irq_vec_set #(.N(NVEC), .W(VEC_W)) u_isr (
        .clk(clk), .rst(rst),
        .set_en(take), .set_idx(p_idx),
        .clr_en(retire), .clr_idx(s_idx),
        .bits_q(isr_q)
    );

    irq_prio_enc #(.N(NVEC), .W(VEC_W)) u_enc_pend (
        .bits(pend_q), .found(p_found), .idx(p_idx)
    );

    irq_prio_enc #(.N(NVEC), .W(VEC_W)) u_enc_isr (
        .bits(isr_q), .found(s_found), .idx(s_idx)
    );

    // Present only when the pending class beats the class being serviced.
    assign presentable = enable_q && p_found &&
                         (!s_found || (class_of(p_idx) > class_of(s_idx)));
    assign take   = ack && presentable;
    assign retire = eoi && s_found;
    assign irq    = presentable;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            spur_q   <= SPUR_RESET;
        end else if (cfg_we) begin
            enable_q <= cfg_enable;
            spur_q   <= cfg_spurious;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
            eoi_q <= '0;
        end else begin
            ack_q.valid    <= ack;
            ack_q.spurious <= ack && !presentable;
            ack_q.vec      <= presentable ? p_idx : spur_q;
            eoi_q.pulse    <= retire;
            eoi_q.vec      <= s_idx;
        end
    end

    assign ack_valid    = ack_q.valid;
    assign ack_spurious = ack_q.spurious;
    assign ack_vec      = ack_q.vec;
    assign eoi_pulse    = eoi_q.pulse;
    assign eoi_vec      = eoi_q.vec;
endmodule

// File: rtl/irq_acceptor_chk.sv
module irq_acceptor_chk #(
    parameter int N = 256,
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         irq,
    input logic         enable_q,
    input logic [W-1:0] spur_q,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] isr_q,
    input logic         ack_valid,
    input logic         ack_spurious,
    input logic [W-1:0] ack_vec,
    input logic         eoi_pulse,
    input logic [W-1:0] eoi_vec
);
    logic [N-1:0] pend_prev, isr_prev;
    logic [W-1:0] spur_prev;

    always_ff @(posedge clk) begin
        pend_prev <= pend_q;
        isr_prev  <= isr_q;
        spur_prev <= spur_q;
    end

    // R2: a pending bit disappears only in the cycle after a real acknowledge
    p_no_withdraw_r2: assert property (@(posedge clk) disable iff (rst)
        !(ack_valid && !ack_spurious) |-> ((pend_prev & ~pend_q) == '0));

    // R3: spurious responses carry the programmed vector
    p_spur_value_r3: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_spurious) |-> (ack_vec == spur_prev));

    // R4: spurious acknowledge leaves the in-service set untouched
    p_spur_isr_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_spurious && !eoi_pulse) |-> (isr_q == isr_prev));

    // R5: end-of-interrupt clears exactly the reported entry
    p_eoi_one_r5: assert property (@(posedge clk) disable iff (rst)
        eoi_pulse |-> (isr_prev[eoi_vec] && !isr_q[eoi_vec] &&
                       $countones(isr_prev & ~isr_q) == 1));

    // R7: a taken vector is now in service
    p_take_isr_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_spurious) |-> isr_q[ack_vec]);

    // R8: no request while disabled
    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !enable_q |-> !irq);
endmodule

bind irq_acceptor irq_acceptor_chk #(.N(irq_acc_pkg::NVEC), .W(irq_acc_pkg::VEC_W)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .enable_q(enable_q), .spur_q(spur_q),
    .pend_q(pend_q), .isr_q(isr_q), .ack_valid(ack_valid),
    .ack_spurious(ack_spurious), .ack_vec(ack_vec),
    .eoi_pulse(eoi_pulse), .eoi_vec(eoi_vec)
);

// File: tb/sim_irq_acceptor.sv
`timescale 1ns/1ps
module sim_irq_acceptor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dlv_valid = 1'b0;
    logic [7:0] dlv_vector = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [7:0] cfg_spurious = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq, ack_valid, ack_spurious, eoi_pulse;
    logic [7:0] ack_vec, eoi_vec;

    int n_chk = 0;
    int n_fail = 0;

    bit [255:0] m_pend, m_isr;
    bit         m_en;
    bit [7:0]   m_spur;
    bit         last_spur;
    string      tag_ovr;

    always #10 clk = ~clk;

    irq_acceptor u0 (
        .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_spurious(cfg_spurious),
        .ack(ack), .eoi(eoi), .irq(irq), .ack_valid(ack_valid),
        .ack_spurious(ack_spurious), .ack_vec(ack_vec),
        .eoi_pulse(eoi_pulse), .eoi_vec(eoi_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int top_of(input bit [255:0] b);
        int r = -1;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    function automatic bit m_present();
        int p = top_of(m_pend);
        int s = top_of(m_isr);
        if (!m_en || p < 0) return 1'b0;
        if (s < 0) return 1'b1;
        return (p >> 4) > (s >> 4);
    endfunction

    task automatic step(input bit dv, input int dvec, input bit ak, input bit eo);
        bit pres = m_present();
        int p = top_of(m_pend);
        int s = top_of(m_isr);
        bit multi = $countones(m_pend) > 1;
        dlv_valid = dv; dlv_vector = 8'(dvec); ack = ak; eoi = eo;
        @(posedge clk); #2;
        dlv_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
        chk("R7 ack_valid", {31'b0, ack_valid}, {31'b0, ak});
        if (ak) begin
            if (pres) begin
                chk(tag_ovr != "" ? tag_ovr : (multi ? "R1 order" : "R7 take"),
                    {24'b0, ack_vec}, p);
                chk("R7 not spurious", {31'b0, ack_spurious}, 0);
            end else begin
                chk(m_en ? "R3 spurious vec" : "R8 disabled ack", {24'b0, ack_vec}, {24'b0, m_spur});
                chk("R3 spurious flag", {31'b0, ack_spurious}, 1);
            end
        end
        chk("R5 eoi pulse", {31'b0, eoi_pulse}, {31'b0, eo && s >= 0});
        if (eo && s >= 0)
            chk(last_spur ? "R4 eoi after spurious" : "R5 eoi vec", {24'b0, eoi_vec}, s);
        // model update: set wins over clear
        if (eo && s >= 0) m_isr[s] = 1'b0;
        if (ak && pres) begin m_pend[p] = 1'b0; m_isr[p] = 1'b1; end
        if (dv) m_pend[dvec] = 1'b1;
        if (ak) last_spur = !pres;
        else if (eo) last_spur = 1'b0;
        chk(m_en ? "R6 irq" : "R8 irq low", {31'b0, irq}, {31'b0, m_present()});
    endtask

    task automatic cfg(input bit en, input int sp);
        cfg_we = 1'b1; cfg_enable = en; cfg_spurious = 8'(sp);
        @(posedge clk); #2;
        cfg_we = 1'b0;
        m_en = en; m_spur = 8'(sp);
        chk(en ? "R6 irq after cfg" : "R8 irq after cfg", {31'b0, irq}, {31'b0, m_present()});
    endtask

    task automatic drain();
        for (int k = 0; k < 600 && (m_pend != 0 || m_isr != 0); k++) begin
            if (m_present()) step(0, 0, 1, 0);
            else             step(0, 0, 0, 1);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_pend = '0; m_isr = '0; m_en = 0; m_spur = 8'hFF; last_spur = 0; tag_ovr = "";
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R9 reset state
        chk("R9 irq", {31'b0, irq}, 0);
        chk("R9 ack_valid", {31'b0, ack_valid}, 0);
        chk("R9 eoi_pulse", {31'b0, eoi_pulse}, 0);
        step(0, 0, 1, 0);   // R9: spurious FF returned while disabled
        step(0, 0, 0, 1);   // R5: eoi with nothing in service

        // R8/R2: deliveries while disabled stay pending
        step(1, 8'h80, 0, 0);
        step(1, 8'h93, 1, 0);
        step(0, 0, 0, 1);
        cfg(1, 8'h17);
        tag_ovr = "R2 kept pending";
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        tag_ovr = "";
        drain();

        // R7/R5 sweep over every vector
        for (int v = 0; v < 256; v++) begin
            step(1, v, 0, 0);
            step(0, 0, 1, 0);
            step(0, 0, 0, 1);
        end

        // R6 class sweep: first vector in service, second arrives
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1, a * 16 + 3, 0, 0);
                step(0, 0, 1, 0);
                step(1, b * 16 + 7, 0, 0);
                step(0, 0, 1, 0);   // taken or spurious (R3/R4)
                drain();
            end
        end

        // R1: several pending, out of order
        step(1, 8'h21, 0, 0);
        step(1, 8'hC4, 0, 0);
        step(1, 8'h77, 0, 0);
        step(1, 8'hC9, 0, 0);
        drain();

        // R4: spurious ack in the middle of nested servicing, then extra eoi
        cfg(1, 8'h3C);
        step(1, 8'h35, 1, 0);
        step(0, 0, 1, 0);
        step(1, 8'h3A, 0, 0);
        step(0, 0, 1, 0);
        step(1, 8'h41, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 1, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);

        // Delivery of the vector being taken in the same cycle stays pending
        step(1, 8'h50, 0, 0);
        step(1, 8'h50, 1, 0);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule